// File: doc/BRIEF.md
# Flat Memory Dispatch Arbiter

This block sits between the schedule queue and the execution stage of a wave-based processor core. Each cycle the schedule queue may place one instruction into each execution-unit slot of a dispatch list. The block resolves the one structural conflict in that list: a flat memory instruction chosen for the global memory pipe also needs the local memory pipe assigned to its wave. That local pipe may already hold an instruction of its own.

Conflicts are resolved in a fixed order. First the flat instruction takes the paired local slot. That slot is marked skip and carries the flat wave, and any local instruction that was there is sent back to the schedule queue with an arbitration stall pulse. Next, every execute-ready slot must obtain destination write ports from both register files. A slot that fails returns to empty and its instruction goes back to the queue. When a flat instruction fails, its skip slot returns to empty as well. All outputs are registered, so the result appears one clock after the inputs. The list is rebuilt from nothing every cycle.

Top module: `fmd_dispatch_arb`

## Requirements
- R1: After reset, every slot state is 0 (empty), all waves are 0, no reinsert is valid and `arb_stall` is low.
- R2: Slot states are 2-bit codes at bits [2j+1:2j]: 0 empty, 1 execute-ready, 2 skip. One cycle after a valid dispatch on slot j whose write ports are granted, slot j is 1 and carries the dispatched wave. A slot with no dispatch is 0 with wave 0.
- R3: A scalar instruction needs only the scalar write port, and `vrf_wr_ok` has no effect on it. A non-scalar instruction needs both ports.
- R4: An execute-ready slot j that is denied a write port becomes empty, and its wave is reinserted on reinsert entry 1+j.
- R5: A flat instruction on slot GM_SLOT, with a valid dispatch on its paired local slot LM_BASE+`gm_lm_idx`, causes the local wave to be reinserted on reinsert entry 0 and a one-cycle `arb_stall` pulse.
- R6: When the flat instruction is valid, its paired local slot is 2 (skip) and carries the flat wave, whether or not that slot had a competing dispatch.
- R7: If the flat instruction fails its write check, both GM_SLOT and its skip slot become empty. The flat wave is reinserted on entry 1+GM_SLOT. A local wave that lost arbitration is still reinserted on entry 0 and does not regain its slot.
- R8: A skip slot is not write-checked, and its own `vrf_wr_ok`/`srf_wr_ok` bits have no effect.
- R9: A non-flat instruction on GM_SLOT leaves the local slots untouched. The flat flag has effect only together with a valid GM_SLOT dispatch.
- R10: No execution unit is granted twice in a cycle. A skip slot always sits beside an execute-ready GM_SLOT that holds the same wave.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| disp_vld | input | NS | Schedule queue placed an instruction in slot j |
| disp_wave | input | NS*WW | Wave id per slot |
| disp_scalar | input | NS | Instruction in slot j is scalar |
| gm_flat | input | 1 | Instruction on GM_SLOT is a flat access |
| gm_lm_idx | input | LW | Local memory pipe index of the GM_SLOT wave |
| vrf_wr_ok | input | NS | Vector register file can take slot j's writes |
| srf_wr_ok | input | NS | Scalar register file can take slot j's writes |
| slot_state | output | NS*2 | Final per-slot state code |
| slot_wave | output | NS*WW | Wave occupying each slot, 0 when empty |
| rein_vld | output | NS+1 | Reinsert requests: entry 0 arbitration, entry 1+j write failure of slot j |
| rein_wave | output | (NS+1)*WW | Wave per reinsert entry |
| arb_stall | output | 1 | Local instruction lost to a flat instruction |

## Verification
The hardest case to reach is a flat instruction that wins arbitration over a valid local instruction and then fails its own write check in the same cycle. Here both reinsert paths fire together, and the skip slot must unwind, while the loser stays out. The bench drives this case directly, with an occupied paired slot and a denied scalar write port on the global slot. It then runs long random phases in which flat, validity and write-port bits are biased so that this combination recurs against the behavioural model.

// File: rtl/fmd_pkg.sv
package fmd_pkg;
   typedef enum logic [1:0] {
      SLOT_EMPTY = 2'd0,
      SLOT_EXRDY = 2'd1,
      SLOT_SKIP  = 2'd2
   } slot_st_e;
endpackage

// File: rtl/fmd_flat_arb.sv
module fmd_flat_arb
   import fmd_pkg::*;
#(
   parameter int NS      = 6,
   parameter int WW      = 6,
   parameter int LW      = 1,
   parameter int GM_SLOT = 3,
   parameter int LM_BASE = 4,
   parameter int NUM_LM  = 2
) (
   input  logic [NS-1:0]    disp_vld,
   input  logic [NS*WW-1:0] disp_wave,
   input  logic             gm_flat,
   input  logic [LW-1:0]    gm_lm_idx,
   output logic [NS*2-1:0]  arb_state,
   output logic [NS*WW-1:0] arb_wave,
   output logic             lose_vld,
   output logic [WW-1:0]    lose_wave
);
   logic          flat_go;
   logic [WW-1:0] gm_wave;
   logic [NS-1:0] hit;

   assign flat_go = disp_vld[GM_SLOT] & gm_flat;
   assign gm_wave = disp_wave[GM_SLOT*WW +: WW];

   for (genvar j = 0; j < NS; j++) begin : g_slot
      if (j >= LM_BASE && j < LM_BASE + NUM_LM) begin : g_lm
         assign hit[j] = flat_go && (gm_lm_idx == LW'(j - LM_BASE));
      end else begin : g_other
         assign hit[j] = 1'b0;
      end

      always_comb begin
         if (hit[j]) begin
            arb_state[j*2 +: 2] = SLOT_SKIP;
            arb_wave[j*WW +: WW] = gm_wave;
         end else if (disp_vld[j]) begin
            arb_state[j*2 +: 2] = SLOT_EXRDY;
            arb_wave[j*WW +: WW] = disp_wave[j*WW +: WW];
         end else begin
            arb_state[j*2 +: 2] = SLOT_EMPTY;
            arb_wave[j*WW +: WW] = '0;
         end
      end
   end

   always_comb begin
      lose_vld  = 1'b0;
      lose_wave = '0;
      for (int k = 0; k < NS; k++) begin
         if (hit[k] && disp_vld[k]) begin
            lose_vld  = 1'b1;
            lose_wave = lose_wave | disp_wave[k*WW +: WW];
         end
      end
   end
endmodule

// File: rtl/fmd_wr_check.sv
module fmd_wr_check
   import fmd_pkg::*;
#(
   parameter int NS      = 6,
   parameter int WW      = 6,
   parameter int GM_SLOT = 3,
   parameter int LM_BASE = 4,
   parameter int NUM_LM  = 2
) (
   input  logic [NS*2-1:0]  arb_state,
   input  logic [NS*WW-1:0] arb_wave,
   input  logic [NS-1:0]    disp_scalar,
   input  logic [NS-1:0]    vrf_wr_ok,
   input  logic [NS-1:0]    srf_wr_ok,
   output logic [NS*2-1:0]  fin_state,
   output logic [NS*WW-1:0] fin_wave,
   output logic [NS-1:0]    wr_fail
);
   logic [NS-1:0] unwind;

   for (genvar j = 0; j < NS; j++) begin : g_slot
      logic exrdy, port_ok, drop;
      assign exrdy   = (arb_state[j*2 +: 2] == SLOT_EXRDY);
      assign port_ok = srf_wr_ok[j] & (disp_scalar[j] | vrf_wr_ok[j]);
      assign wr_fail[j] = exrdy & ~port_ok;

      if (j >= LM_BASE && j < LM_BASE + NUM_LM) begin : g_lm
         assign unwind[j] = (arb_state[j*2 +: 2] == SLOT_SKIP) & wr_fail[GM_SLOT];
      end else begin : g_other
         assign unwind[j] = 1'b0;
      end

      assign drop = wr_fail[j] | unwind[j];
      assign fin_state[j*2 +: 2] = drop ? SLOT_EMPTY : arb_state[j*2 +: 2];
      assign fin_wave[j*WW +: WW] = drop ? '0 : arb_wave[j*WW +: WW];
   end
endmodule

// File: rtl/fmd_dispatch_arb.sv
module fmd_dispatch_arb
   import fmd_pkg::*;
#(
   parameter int NS      = 6,
   parameter int WW      = 6,
   parameter int GM_SLOT = 3,
   parameter int LM_BASE = 4,
   parameter int NUM_LM  = 2,
   parameter int LW      = (NUM_LM > 1) ? $clog2(NUM_LM) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NS-1:0]        disp_vld,
   input  logic [NS*WW-1:0]     disp_wave,
   input  logic [NS-1:0]        disp_scalar,
   input  logic                 gm_flat,
   input  logic [LW-1:0]        gm_lm_idx,
   input  logic [NS-1:0]        vrf_wr_ok,
   input  logic [NS-1:0]        srf_wr_ok,
   output logic [NS*2-1:0]      slot_state,
   output logic [NS*WW-1:0]     slot_wave,
   output logic [NS:0]          rein_vld,
   output logic [(NS+1)*WW-1:0] rein_wave,
   output logic                 arb_stall
);
   localparam int RW = (NS + 1) * WW;

   if (NUM_LM < 2 || (NUM_LM & (NUM_LM - 1)) != 0) begin : g_bad_lm
      $error("NUM_LM must be a power of two, at least 2");
   end
   if (GM_SLOT >= NS || LM_BASE + NUM_LM > NS) begin : g_bad_range
      $error("slot indices exceed NS");
   end
   if (GM_SLOT >= LM_BASE && GM_SLOT < LM_BASE + NUM_LM) begin : g_bad_overlap
      $error("GM_SLOT overlaps the local memory slots");
   end

   logic [NS*2-1:0]  arb_state, fin_state;
   logic [NS*WW-1:0] arb_wave, fin_wave;
   logic             lose_vld;
   logic [WW-1:0]    lose_wave;
   logic [NS-1:0]    wr_fail;
   logic [RW-1:0]    rein_wave_d;

   fmd_flat_arb #(
      .NS(NS), .WW(WW), .LW(LW), .GM_SLOT(GM_SLOT),
      .LM_BASE(LM_BASE), .NUM_LM(NUM_LM)
   ) u_arb (
      .disp_vld  (disp_vld),
      .disp_wave (disp_wave),
      .gm_flat   (gm_flat),
      .gm_lm_idx (gm_lm_idx),
      .arb_state (arb_state),
      .arb_wave  (arb_wave),
      .lose_vld  (lose_vld),
      .lose_wave (lose_wave)
   );

   fmd_wr_check #(
      .NS(NS), .WW(WW), .GM_SLOT(GM_SLOT),
      .LM_BASE(LM_BASE), .NUM_LM(NUM_LM)
   ) u_wr (
      .arb_state   (arb_state),
      .arb_wave    (arb_wave),
      .disp_scalar (disp_scalar),
      .vrf_wr_ok   (vrf_wr_ok),
      .srf_wr_ok   (srf_wr_ok),
      .fin_state   (fin_state),
      .fin_wave    (fin_wave),
      .wr_fail     (wr_fail)
   );

   assign rein_wave_d[0 +: WW] = lose_wave;
   for (genvar j = 0; j < NS; j++) begin : g_rein
      assign rein_wave_d[(j+1)*WW +: WW] = wr_fail[j] ? arb_wave[j*WW +: WW] : '0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         slot_state <= '0;
         slot_wave  <= '0;
         rein_vld   <= '0;
         rein_wave  <= '0;
         arb_stall  <= 1'b0;
      end else begin
         slot_state <= fin_state;
         slot_wave  <= fin_wave;
         rein_vld   <= {wr_fail, lose_vld};
         rein_wave  <= rein_wave_d;
         arb_stall  <= lose_vld;
      end
   end
endmodule

// File: rtl/fmd_checker.sv
module fmd_checker #(
   parameter int NS      = 6,
   parameter int WW      = 6,
   parameter int GM_SLOT = 3,
   parameter int LM_BASE = 4,
   parameter int NUM_LM  = 2,
   parameter int LW      = 1
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [NS-1:0]        disp_vld,
   input logic [NS*WW-1:0]     disp_wave,
   input logic [NS-1:0]        disp_scalar,
   input logic                 gm_flat,
   input logic [LW-1:0]        gm_lm_idx,
   input logic [NS-1:0]        vrf_wr_ok,
   input logic [NS-1:0]        srf_wr_ok,
   input logic [NS*2-1:0]      slot_state,
   input logic [NS*WW-1:0]     slot_wave,
   input logic [NS:0]          rein_vld,
   input logic [(NS+1)*WW-1:0] rein_wave,
   input logic                 arb_stall
);
   p_stall_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
      arb_stall |-> $past(disp_vld[GM_SLOT] && gm_flat));

   p_unwind_r7: assert property (@(posedge clk) disable iff (!rst_n)
      rein_vld[GM_SLOT+1] |-> slot_state[GM_SLOT*2 +: 2] == 2'd0);

   for (genvar j = 0; j < NS; j++) begin : g_slot
      p_exrdy_src_r2: assert property (@(posedge clk) disable iff (!rst_n)
         slot_state[j*2 +: 2] == 2'd1 |->
            $past(disp_vld[j]) && slot_wave[j*WW +: WW] == $past(disp_wave[j*WW +: WW]));

      p_ports_r3: assert property (@(posedge clk) disable iff (!rst_n)
         slot_state[j*2 +: 2] == 2'd1 |->
            $past(srf_wr_ok[j]) && ($past(disp_scalar[j]) || $past(vrf_wr_ok[j])));

      p_fail_empty_r4: assert property (@(posedge clk) disable iff (!rst_n)
         rein_vld[j+1] |-> slot_state[j*2 +: 2] == 2'd0 && $past(disp_vld[j]));

      if (j >= LM_BASE && j < LM_BASE + NUM_LM) begin : g_lm
         p_skip_pair_r10: assert property (@(posedge clk) disable iff (!rst_n)
            slot_state[j*2 +: 2] == 2'd2 |->
               slot_state[GM_SLOT*2 +: 2] == 2'd1 &&
               slot_wave[j*WW +: WW] == slot_wave[GM_SLOT*WW +: WW]);

         p_no_double_grant_r10: assert property (@(posedge clk) disable iff (!rst_n)
            (slot_state[GM_SLOT*2 +: 2] == 2'd1 && $past(gm_flat) &&
             $past(gm_lm_idx) == LW'(j - LM_BASE)) |-> slot_state[j*2 +: 2] == 2'd2);
      end
   end
endmodule

bind fmd_dispatch_arb fmd_checker #(
   .NS(NS), .WW(WW), .GM_SLOT(GM_SLOT), .LM_BASE(LM_BASE), .NUM_LM(NUM_LM), .LW(LW)
) u_chk (.*);

// File: tb/fmd_dispatch_arb_tb_top.sv
`timescale 1ns/1ps
module fmd_dispatch_arb_tb_top;
   localparam int NS = 6, WW = 6, GM = 3, LMB = 4, NLM = 2, LW = 1;

   logic                 clk = 1'b0;
   logic                 rst_n = 1'b0;
   logic [NS-1:0]        disp_vld = '0, disp_scalar = '0, vrf_wr_ok = '0, srf_wr_ok = '0;
   logic [NS*WW-1:0]     disp_wave = '0;
   logic                 gm_flat = 1'b0;
   logic [LW-1:0]        gm_lm_idx = '0;
   logic [NS*2-1:0]      slot_state;
   logic [NS*WW-1:0]     slot_wave;
   logic [NS:0]          rein_vld;
   logic [(NS+1)*WW-1:0] rein_wave;
   logic                 arb_stall;

   always #2 clk = ~clk;

   fmd_dispatch_arb #(.NS(NS), .WW(WW), .GM_SLOT(GM), .LM_BASE(LMB), .NUM_LM(NLM)) dut_i (.*);

   int checks = 0, fails = 0;
   bit done = 0;

   int e_st[NS], e_wv[NS], e_rv[NS+1], e_rw[NS+1];
   int e_stall;

   task automatic model();
      int lm;
      bit fgo;
      for (int j = 0; j < NS; j++) begin
         e_st[j] = disp_vld[j] ? 1 : 0;
         e_wv[j] = disp_vld[j] ? int'(disp_wave[j*WW +: WW]) : 0;
      end
      for (int j = 0; j <= NS; j++) begin e_rv[j] = 0; e_rw[j] = 0; end
      fgo = disp_vld[GM] && gm_flat;
      lm  = LMB + int'(gm_lm_idx);
      if (fgo) begin
         if (disp_vld[lm]) begin e_rv[0] = 1; e_rw[0] = int'(disp_wave[lm*WW +: WW]); end
         e_st[lm] = 2;
         e_wv[lm] = int'(disp_wave[GM*WW +: WW]);
      end
      e_stall = e_rv[0];
      for (int j = 0; j < NS; j++) begin
         if (e_st[j] == 1 && !(srf_wr_ok[j] && (disp_scalar[j] || vrf_wr_ok[j]))) begin
            e_rv[j+1] = 1; e_rw[j+1] = e_wv[j]; e_st[j] = 0; e_wv[j] = 0;
         end
      end
      if (fgo && e_rv[GM+1] == 1) begin e_st[lm] = 0; e_wv[lm] = 0; end
   endtask

   task automatic compare(string tag);
      for (int j = 0; j < NS; j++) begin
         checks++;
         if (int'(slot_state[j*2 +: 2]) != e_st[j] || int'(slot_wave[j*WW +: WW]) != e_wv[j]) begin
            fails++;
            $display("FAIL %s slot %0d state/wave actual %0d/%0d expected %0d/%0d", tag, j,
                     slot_state[j*2 +: 2], slot_wave[j*WW +: WW], e_st[j], e_wv[j]);
         end
      end
      for (int j = 0; j <= NS; j++) begin
         checks++;
         if (int'(rein_vld[j]) != e_rv[j] || int'(rein_wave[j*WW +: WW]) != e_rw[j]) begin
            fails++;
            $display("FAIL %s reinsert %0d vld/wave actual %0d/%0d expected %0d/%0d", tag, j,
                     rein_vld[j], rein_wave[j*WW +: WW], e_rv[j], e_rw[j]);
         end
      end
      checks++;
      if (int'(arb_stall) != e_stall) begin
         fails++;
         $display("FAIL %s arb_stall actual %0d expected %0d", tag, arb_stall, e_stall);
      end
   endtask

   task automatic set_slot(int j, bit v, int w, bit sc, bit vo, bit so);
      disp_vld[j] = v; disp_wave[j*WW +: WW] = WW'(w);
      disp_scalar[j] = sc; vrf_wr_ok[j] = vo; srf_wr_ok[j] = so;
   endtask

   task automatic clear_in();
      disp_vld = '0; disp_wave = '0; disp_scalar = '0;
      vrf_wr_ok = '1; srf_wr_ok = '1; gm_flat = 0; gm_lm_idx = '0;
   endtask

   task automatic step(string tag);
      model();
      @(negedge clk);
      compare(tag);
   endtask

   initial begin
      #(4 * 200000);
      if (!done) begin
         fails++; checks++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      for (int j = 0; j < NS; j++) begin e_st[j] = 0; e_wv[j] = 0; end
      for (int j = 0; j <= NS; j++) begin e_rv[j] = 0; e_rw[j] = 0; end
      e_stall = 0;
      compare("R1");
      rst_n = 1'b1;

      clear_in();
      set_slot(0, 1, 11, 0, 1, 1); set_slot(1, 1, 12, 1, 1, 1); set_slot(2, 1, 13, 0, 1, 1);
      step("R2");

      clear_in();
      set_slot(0, 1, 21, 1, 0, 1); set_slot(1, 1, 22, 0, 0, 1); set_slot(2, 1, 23, 1, 1, 0);
      step("R3");

      clear_in();
      set_slot(1, 1, 31, 0, 1, 0); set_slot(4, 1, 32, 0, 0, 1);
      step("R4");

      clear_in();
      set_slot(GM, 1, 41, 0, 1, 1); gm_flat = 1; gm_lm_idx = 0; set_slot(4, 1, 42, 0, 1, 1);
      step("R5");

      clear_in();
      set_slot(GM, 1, 51, 0, 1, 1); gm_flat = 1; gm_lm_idx = 1;
      step("R6");

      clear_in();
      set_slot(GM, 1, 61, 1, 1, 0); gm_flat = 1; gm_lm_idx = 0; set_slot(4, 1, 62, 0, 1, 1);
      step("R7");

      clear_in();
      set_slot(GM, 1, 7, 0, 1, 1); gm_flat = 1; gm_lm_idx = 1; set_slot(5, 1, 8, 0, 0, 0);
      step("R8");

      clear_in();
      set_slot(GM, 1, 15, 0, 1, 1); set_slot(4, 1, 16, 0, 1, 1); set_slot(5, 1, 17, 1, 1, 1);
      step("R9");

      clear_in();
      gm_flat = 1;
      step("R9");

      for (int c = 0; c < 3000; c++) begin
         string tag;
         for (int j = 0; j < NS; j++)
            set_slot(j, ($urandom % 4) != 0, int'($urandom % 64), $urandom % 2,
                     ($urandom % 5) != 0, ($urandom % 5) != 0);
         gm_flat = ($urandom % 2) == 1;
         gm_lm_idx = LW'($urandom % NLM);
         model();
         tag = "R2";
         for (int j = 1; j <= NS; j++) if (e_rv[j] != 0) tag = "R4";
         if (e_stall != 0) tag = "R5";
         @(negedge clk);
         compare(tag);
         for (int j = LMB; j < LMB + NLM; j++) begin
            if (slot_state[j*2 +: 2] == 2'd2) begin
               checks++;
               if (slot_state[GM*2 +: 2] != 2'd1 || slot_wave[j*WW +: WW] != slot_wave[GM*WW +: WW]) begin
                  fails++;
                  $display("FAIL R10 skip slot %0d wave actual %0d expected %0d", j,
                           slot_wave[j*WW +: WW], slot_wave[GM*WW +: WW]);
               end
            end
         end
      end

      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule